// File: doc/BRIEF.md
# Banked Memory Conflict Arbiter

This block sits in front of a banked on-chip memory and serves four request sources in the same clock cycle. The sources are two 64-bit processor data ports, one 32-bit port from the peripheral and DMA side, and one 256-bit port that fetches whole instruction lines. Behind the arbiter are two read-only pages and one read-write page. Each read-only page has four banks that are 64 bits wide. The read-write page has eight banks that are 32 bits wide. Each cycle the block works out which page and which banks every request touches. It grants as many requests as can proceed together, up to three, and stalls the others.

A stalled source keeps its request and address asserted and is granted in a later cycle. The grant is combinational and appears in the cycle of the request. Read data comes back from a register one cycle after the grant. The read-only contents are computed from page, bank and row, so no stored image is needed. The read-write banks are register arrays with byte write enables. The parameter `ROW_W` sets the number of rows held per bank, and rows above that range alias.

Top module: `banked_mem_arbiter`

## Requirements
- R1: Fixed priority, highest first: data port 0, data port 1, peripheral port, line fetch. Data port 0 is always granted when it requests. A conflicting request of lower priority is not granted while it conflicts, and there is no grant without a request.
- R2: At most three grants are issued per cycle. When all four sources request without conflicting, the line fetch stalls and is granted once it is the third or earlier candidate.
- R3: Page decode works on byte addresses. Read-only page 0 covers 0x0000_0000 to 0x0003_FFFF, read-only page 1 covers 0x0004_0000 to 0x0005_FFFF, and the read-write page covers 0x1000_0000 to 0x1003_FFFF. Any other address is granted without conflict, reads as zero, and its writes are dropped.
- R4: Two data accesses conflict only when they are on the same page and share a bank. On read-only pages the bank is addr[4:3]. On the read-write page, a 32-bit access uses bank addr[4:2], and a 64-bit access occupies the bank pair 2*addr[4:3] and 2*addr[4:3]+1.
- R5: A line fetch conflicts with every data access to its own page, whatever the bank. A line fetch and data accesses on other pages are granted together.
- R6: A granted read raises the port's rvalid, with its data, exactly one cycle after the grant. rvalid stays low after a write grant and after a cycle without a grant.
- R7: The row is addr[5 +: ROW_W]. A read-only word is two copies of {8'hB0 | page, 8'(bank), 16'(row)}. A 32-bit read of a read-only page returns the upper half when addr[2] is 1. A line fetch returns bank 0 in the least significant bits.
- R8: Writes to the read-only pages have no effect on later reads.
- R9: Byte enables select the bytes written on the read-write page. A 64-bit access is little-endian: bank 2k holds the low word.
- R10: Reset clears every rvalid and every read-write location to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d0_req | input | 1 | Data port 0 request |
| d0_we | input | 1 | Data port 0 write |
| d0_addr | input | 32 | Data port 0 byte address |
| d0_wdata | input | 64 | Data port 0 write data |
| d0_be | input | 8 | Data port 0 byte enables |
| d0_gnt | output | 1 | Data port 0 grant (same cycle) |
| d0_rvalid | output | 1 | Data port 0 read data valid |
| d0_rdata | output | 64 | Data port 0 read data |
| d1_req | input | 1 | Data port 1 request |
| d1_we | input | 1 | Data port 1 write |
| d1_addr | input | 32 | Data port 1 byte address |
| d1_wdata | input | 64 | Data port 1 write data |
| d1_be | input | 8 | Data port 1 byte enables |
| d1_gnt | output | 1 | Data port 1 grant |
| d1_rvalid | output | 1 | Data port 1 read data valid |
| d1_rdata | output | 64 | Data port 1 read data |
| pr_req | input | 1 | Peripheral port request |
| pr_we | input | 1 | Peripheral port write |
| pr_addr | input | 32 | Peripheral port byte address |
| pr_wdata | input | 32 | Peripheral port write data |
| pr_be | input | 4 | Peripheral port byte enables |
| pr_gnt | output | 1 | Peripheral port grant |
| pr_rvalid | output | 1 | Peripheral port read data valid |
| pr_rdata | output | 32 | Peripheral port read data |
| pf_req | input | 1 | Line fetch request |
| pf_addr | input | 32 | Line fetch byte address |
| pf_gnt | output | 1 | Line fetch grant |
| pf_rvalid | output | 1 | Line fetch data valid |
| pf_rdata | output | 256 | Line fetch data |

## Verification
Grant decisions are tried with several request patterns. Pairs on the same bank separate the priority order from bank overlap. Pairs on neighbouring banks show that two accesses to one page can proceed together. A 64-bit access against a 32-bit access on the read-write page shows that the wide access occupies two banks. A line fetch tried against a data access on its own page and then on another page separates page-level conflicts from bank-level ones. Four requests that do not conflict expose the three-grant limit. Reads after partial writes, write attempts on the read-only pages, and accesses outside every page test the data path: lane order, byte masking and the zero response.

// File: rtl/bma_pkg.sv
package bma_pkg;

    typedef enum logic [1:0] {
        PG_ROM0 = 2'd0,
        PG_ROM1 = 2'd1,
        PG_RAM  = 2'd2,
        PG_NONE = 2'd3
    } page_e;

    localparam int NPORT     = 4;
    localparam int RAM_BANKS = 8;
    localparam int ROM_BANKS = 4;

    // Width in bytes of each source, index order equals priority order
    function automatic int port_bytes(input int p);
        case (p)
            0, 1:    return 8;
            2:       return 4;
            default: return 32;
        endcase
    endfunction

    // Computed read-only content
    function automatic logic [63:0] rom_word(input logic pg_hi,
                                             input logic [1:0] bank,
                                             input logic [15:0] row);
        logic [31:0] h;
        h = {7'h58, pg_hi, 6'd0, bank, row};
        return {h, h};
    endfunction

endpackage

// File: rtl/bma_decode.sv
module bma_decode
    import bma_pkg::*;
#(
    parameter int WBYTES = 8,
    parameter int ROW_W  = 4
) (
    input  logic [31:0]      addr,
    output page_e            page,
    output logic [7:0]       bmask,
    output logic [ROW_W-1:0] row
);

    logic unused_addr;
    assign unused_addr = ^addr;

    always_comb begin
        if (addr[31:18] == 14'h0000)
            page = PG_ROM0;
        else if (addr[31:17] == 15'd2)
            page = PG_ROM1;
        else if (addr[31:18] == 14'h0400)
            page = PG_RAM;
        else
            page = PG_NONE;
    end

    assign row = addr[5 +: ROW_W];

    generate
        if (WBYTES >= 32) begin : g_line
            always_comb begin
                unique case (page)
                    PG_RAM:           bmask = 8'hFF;
                    PG_ROM0, PG_ROM1: bmask = 8'h0F;
                    default:          bmask = 8'h00;
                endcase
            end
        end else if (WBYTES == 8) begin : g_dword
            always_comb begin
                unique case (page)
                    PG_RAM:           bmask = 8'b11 << {addr[4:3], 1'b0};
                    PG_ROM0, PG_ROM1: bmask = 8'b1 << addr[4:3];
                    default:          bmask = 8'h00;
                endcase
            end
        end else begin : g_word
            always_comb begin
                unique case (page)
                    PG_RAM:           bmask = 8'b1 << addr[4:2];
                    PG_ROM0, PG_ROM1: bmask = 8'b1 << addr[4:3];
                    default:          bmask = 8'h00;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/bma_grant.sv
module bma_grant
    import bma_pkg::*;
#(
    parameter int N    = 4,
    parameter int MAXG = 3
) (
    input  logic [N-1:0]        req,
    input  page_e [N-1:0]       page,
    input  logic [N-1:0][7:0]   bmask,
    output logic [N-1:0]        gnt
);

    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;
    logic          ok;

    always_comb begin
        gnt = '0;
        cnt = '0;
        ok  = 1'b0;
        for (int i = 0; i < N; i++) begin
            ok = req[i] && (int'(cnt) < MAXG);
            for (int j = 0; j < N; j++) begin
                if (j < i && gnt[j] && page[j] == page[i] &&
                    (bmask[j] & bmask[i]) != 8'h00)
                    ok = 1'b0;
            end
            gnt[i] = ok;
            cnt    = cnt + CW'(ok);
        end
    end

endmodule

// File: rtl/bma_ram_bank.sv
module bma_ram_bank #(
    parameter int ROW_W = 4,
    parameter int NRD   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [3:0]                be,
    input  logic [ROW_W-1:0]          wrow,
    input  logic [31:0]               wdata,
    input  logic [NRD-1:0][ROW_W-1:0] rrow,
    output logic [NRD-1:0][31:0]      rdata
);

    localparam int ROWS = 1 << ROW_W;

    logic [31:0] mem [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                mem[r] <= '0;
        end else if (we) begin
            for (int b = 0; b < 4; b++)
                if (be[b])
                    mem[wrow][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    always_comb begin
        for (int p = 0; p < NRD; p++)
            rdata[p] = mem[rrow[p]];
    end

endmodule

// File: rtl/banked_mem_arbiter.sv
module banked_mem_arbiter
    import bma_pkg::*;
#(
    parameter int ROW_W     = 4,
    parameter int MAX_GRANT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d0_req,
    input  logic         d0_we,
    input  logic [31:0]  d0_addr,
    input  logic [63:0]  d0_wdata,
    input  logic [7:0]   d0_be,
    output logic         d0_gnt,
    output logic         d0_rvalid,
    output logic [63:0]  d0_rdata,
    input  logic         d1_req,
    input  logic         d1_we,
    input  logic [31:0]  d1_addr,
    input  logic [63:0]  d1_wdata,
    input  logic [7:0]   d1_be,
    output logic         d1_gnt,
    output logic         d1_rvalid,
    output logic [63:0]  d1_rdata,
    input  logic         pr_req,
    input  logic         pr_we,
    input  logic [31:0]  pr_addr,
    input  logic [31:0]  pr_wdata,
    input  logic [3:0]   pr_be,
    output logic         pr_gnt,
    output logic         pr_rvalid,
    output logic [31:0]  pr_rdata,
    input  logic         pf_req,
    input  logic [31:0]  pf_addr,
    output logic         pf_gnt,
    output logic         pf_rvalid,
    output logic [255:0] pf_rdata
);

    localparam int NP = NPORT;
    localparam int NB = RAM_BANKS;
    localparam int ND = 3;   // sources that may write

    logic [NP-1:0][31:0]      addr_v;
    logic [NP-1:0]            req_v;
    logic [NP-1:0]            we_v;
    page_e [NP-1:0]           pg_v;
    logic [NP-1:0][7:0]       msk_v;
    logic [NP-1:0][ROW_W-1:0] row_v;
    logic [NP-1:0]            gnt_v;
    logic [ND-1:0][63:0]      wd_v;
    logic [ND-1:0][7:0]       wbe_v;
    logic [NB-1:0][NP-1:0][31:0] bank_rd;
    logic [NP-1:0][255:0]     rd_nx;
    logic [NP-1:0][255:0]     rdata_q;
    logic [NP-1:0]            rvalid_q;

    assign addr_v = {pf_addr, pr_addr, d1_addr, d0_addr};
    assign req_v  = {pf_req, pr_req, d1_req, d0_req};
    assign we_v   = {1'b0, pr_we, d1_we, d0_we};
    assign wd_v   = {{32'h0, pr_wdata}, d1_wdata, d0_wdata};
    assign wbe_v  = {{4'h0, pr_be}, d1_be, d0_be};

    // Address decode, one per source
    generate
        for (genvar p = 0; p < NP; p++) begin : g_dec
            bma_decode #(
                .WBYTES (port_bytes(p)),
                .ROW_W  (ROW_W)
            ) u_dec (
                .addr  (addr_v[p]),
                .page  (pg_v[p]),
                .bmask (msk_v[p]),
                .row   (row_v[p])
            );
        end
    endgenerate

    bma_grant #(
        .N    (NP),
        .MAXG (MAX_GRANT)
    ) u_grant (
        .req   (req_v),
        .page  (pg_v),
        .bmask (msk_v),
        .gnt   (gnt_v)
    );

    // Read-write banks with per-bank write steering
    generate
        for (genvar k = 0; k < NB; k++) begin : g_bank
            localparam int HALF = k % 2;
            logic             bwe;
            logic [3:0]       bbe;
            logic [31:0]      bwd;
            logic [ROW_W-1:0] brow;

            always_comb begin
                bwe  = 1'b0;
                bbe  = '0;
                bwd  = '0;
                brow = '0;
                for (int p = 0; p < ND; p++) begin
                    if (gnt_v[p] && we_v[p] && pg_v[p] == PG_RAM && msk_v[p][k]) begin
                        bwe  = 1'b1;
                        brow = row_v[p];
                        if (port_bytes(p) == 8) begin
                            bbe = wbe_v[p][HALF*4 +: 4];
                            bwd = wd_v[p][HALF*32 +: 32];
                        end else begin
                            bbe = wbe_v[p][3:0];
                            bwd = wd_v[p][31:0];
                        end
                    end
                end
            end

            bma_ram_bank #(
                .ROW_W (ROW_W),
                .NRD   (NP)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (bwe),
                .be    (bbe),
                .wrow  (brow),
                .wdata (bwd),
                .rrow  (row_v),
                .rdata (bank_rd[k])
            );
        end
    endgenerate

    // Read data selection per source
    always_comb begin
        logic        hi;
        logic [63:0] w;
        for (int p = 0; p < NP; p++) begin
            rd_nx[p] = '0;
            hi = (pg_v[p] == PG_ROM1);
            w  = rom_word(hi, addr_v[p][4:3], 16'(row_v[p]));
            unique case (pg_v[p])
                PG_ROM0, PG_ROM1: begin
                    if (port_bytes(p) == 32) begin
                        for (int b = 0; b < ROM_BANKS; b++)
                            rd_nx[p][64*b +: 64] = rom_word(hi, 2'(b), 16'(row_v[p]));
                    end else if (port_bytes(p) == 8) begin
                        rd_nx[p][63:0] = w;
                    end else begin
                        rd_nx[p][31:0] = addr_v[p][2] ? w[63:32] : w[31:0];
                    end
                end
                PG_RAM: begin
                    if (port_bytes(p) == 32) begin
                        for (int b = 0; b < NB; b++)
                            rd_nx[p][32*b +: 32] = bank_rd[b][p];
                    end else if (port_bytes(p) == 8) begin
                        rd_nx[p][63:0] = {bank_rd[{addr_v[p][4:3], 1'b1}][p],
                                          bank_rd[{addr_v[p][4:3], 1'b0}][p]};
                    end else begin
                        rd_nx[p][31:0] = bank_rd[addr_v[p][4:2]][p];
                    end
                end
                default: rd_nx[p] = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= '0;
            rdata_q  <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                rvalid_q[p] <= gnt_v[p] & ~we_v[p];
                if (gnt_v[p] && !we_v[p])
                    rdata_q[p] <= rd_nx[p];
            end
        end
    end

    logic unused_sink;
    assign unused_sink = ^{rdata_q[0][255:64], rdata_q[1][255:64],
                           rdata_q[2][255:32], wd_v[2][63:32], wbe_v[2][7:4]};

    assign d0_gnt    = gnt_v[0];
    assign d1_gnt    = gnt_v[1];
    assign pr_gnt    = gnt_v[2];
    assign pf_gnt    = gnt_v[3];
    assign d0_rvalid = rvalid_q[0];
    assign d1_rvalid = rvalid_q[1];
    assign pr_rvalid = rvalid_q[2];
    assign pf_rvalid = rvalid_q[3];
    assign d0_rdata  = rdata_q[0][63:0];
    assign d1_rdata  = rdata_q[1][63:0];
    assign pr_rdata  = rdata_q[2][31:0];
    assign pf_rdata  = rdata_q[3];

endmodule

// File: rtl/bma_chk.sv
module bma_chk #(
    parameter int MAXG = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      req,
    input logic [3:0]      gnt,
    input logic [3:0]      we,
    input logic [3:0]      rvalid,
    input logic [3:0][1:0] pg,
    input logic [3:0][7:0] msk
);

    // R1
    top_port_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);

    // R1
    gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == 4'b0000);

    // R2
    grant_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt) <= MAXG);

    generate
        for (genvar i = 0; i < 4; i++) begin : g_port
            // R6
            rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt[i] && !we[i]) |=> rvalid[i]);
            // R6
            rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(gnt[i] && !we[i]) |=> !rvalid[i]);
            for (genvar j = i + 1; j < 4; j++) begin : g_pair
                // R4 R5
                no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt[i] && gnt[j] && pg[i] == pg[j]) |-> (msk[i] & msk[j]) == 8'h00);
            end
        end
    endgenerate

endmodule

bind banked_mem_arbiter bma_chk #(
    .MAXG (MAX_GRANT)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_v),
    .gnt    (gnt_v),
    .we     (we_v),
    .rvalid (rvalid_q),
    .pg     (pg_v),
    .msk    (msk_v)
);

// File: tb/test_banked_mem_arbiter.sv
module test_banked_mem_arbiter;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         d0_req = 0, d0_we = 0;
    logic [31:0]  d0_addr = 0;
    logic [63:0]  d0_wdata = 0;
    logic [7:0]   d0_be = 0;
    logic         d0_gnt, d0_rvalid;
    logic [63:0]  d0_rdata;
    logic         d1_req = 0, d1_we = 0;
    logic [31:0]  d1_addr = 0;
    logic [63:0]  d1_wdata = 0;
    logic [7:0]   d1_be = 0;
    logic         d1_gnt, d1_rvalid;
    logic [63:0]  d1_rdata;
    logic         pr_req = 0, pr_we = 0;
    logic [31:0]  pr_addr = 0;
    logic [31:0]  pr_wdata = 0;
    logic [3:0]   pr_be = 0;
    logic         pr_gnt, pr_rvalid;
    logic [31:0]  pr_rdata;
    logic         pf_req = 0;
    logic [31:0]  pf_addr = 0;
    logic         pf_gnt, pf_rvalid;
    logic [255:0] pf_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_mem_arbiter i_banked_mem_arbiter (
        .clk(clk), .rst_n(rst_n),
        .d0_req(d0_req), .d0_we(d0_we), .d0_addr(d0_addr), .d0_wdata(d0_wdata),
        .d0_be(d0_be), .d0_gnt(d0_gnt), .d0_rvalid(d0_rvalid), .d0_rdata(d0_rdata),
        .d1_req(d1_req), .d1_we(d1_we), .d1_addr(d1_addr), .d1_wdata(d1_wdata),
        .d1_be(d1_be), .d1_gnt(d1_gnt), .d1_rvalid(d1_rvalid), .d1_rdata(d1_rdata),
        .pr_req(pr_req), .pr_we(pr_we), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
        .pr_be(pr_be), .pr_gnt(pr_gnt), .pr_rvalid(pr_rvalid), .pr_rdata(pr_rdata),
        .pf_req(pf_req), .pf_addr(pf_addr), .pf_gnt(pf_gnt), .pf_rvalid(pf_rvalid),
        .pf_rdata(pf_rdata)
    );

    function automatic logic [63:0] romw(input int p, input int b, input int r);
        logic [31:0] h;
        h = {8'hB0 | 8'(p), 8'(b), 16'(r)};
        return {h, h};
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        d0_req = 0; d0_we = 0; d1_req = 0; d1_we = 0;
        pr_req = 0; pr_we = 0; pf_req = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drv_d0(input logic we, input logic [31:0] a, input logic [63:0] wd, input logic [7:0] be);
        d0_req = 1; d0_we = we; d0_addr = a; d0_wdata = wd; d0_be = be;
    endtask

    task automatic drv_d1(input logic we, input logic [31:0] a);
        d1_req = 1; d1_we = we; d1_addr = a; d1_wdata = '1; d1_be = 8'hFF;
    endtask

    task automatic drv_pr(input logic we, input logic [31:0] a);
        pr_req = 1; pr_we = we; pr_addr = a; pr_wdata = '1; pr_be = 4'hF;
    endtask

    task automatic t_reset();
        #1;
        chk("R10 rvalid low in reset", {d0_rvalid, d1_rvalid, pr_rvalid, pf_rvalid}, 0);
        @(negedge clk); rst_n = 1;
        drv_d0(0, 32'h1000_0040, 0, 0);
        #1 chk("R1 d0 granted", d0_gnt, 1);
        step();
        chk("R6 rvalid after read", d0_rvalid, 1);
        chk("R10 ram cleared", d0_rdata, 0);
        @(negedge clk); idle_all();
        step();
        chk("R6 rvalid low when idle", d0_rvalid, 0);
    endtask

    task automatic t_ram_be();
        @(negedge clk); drv_d0(1, 32'h1000_0008, 64'h1122_3344_5566_7788, 8'hFF);
        step();
        chk("R6 no rvalid on write", d0_rvalid, 0);
        @(negedge clk); drv_d0(1, 32'h1000_0008, 64'hAAAA_AAAA_BBBB_BBBB, 8'h0F);
        step();
        @(negedge clk); drv_d0(0, 32'h1000_0008, 0, 0);
        step();
        chk("R9 byte enables", d0_rdata, 64'h1122_3344_BBBB_BBBB);
        @(negedge clk); idle_all(); drv_pr(0, 32'h1000_000C);
        step();
        chk("R9 high word in odd bank", pr_rdata, 32'h1122_3344);
        @(negedge clk); drv_pr(0, 32'h1000_0008);
        step();
        chk("R9 low word in even bank", pr_rdata, 32'hBBBB_BBBB);
        @(negedge clk); idle_all();
    endtask

    task automatic t_rom_write();
        @(negedge clk); drv_d0(1, 32'h0000_0010, '1, 8'hFF);
        step();
        @(negedge clk); drv_pr(1, 32'h0004_0004);
        d0_we = 0;
        step();
        chk("R8 rom write ignored d0", d0_rdata, romw(0, 2, 0));
        @(negedge clk); idle_all(); drv_d1(0, 32'h0004_0000);
        step();
        chk("R8 rom write ignored pr", d1_rdata, romw(1, 0, 0));
        @(negedge clk); idle_all();
    endtask

    task automatic t_rom_read();
        @(negedge clk); drv_d1(0, 32'h0004_0028);
        step();
        chk("R7 R3 rom page1 word", d1_rdata, romw(1, 1, 1));
        @(negedge clk); idle_all(); drv_pr(0, 32'h0000_0044);
        step();
        chk("R7 rom upper half", pr_rdata, romw(0, 0, 2) >> 32);
        @(negedge clk); idle_all(); pf_req = 1; pf_addr = 32'h0004_0060;
        step();
        chk("R7 line fetch", pf_rdata, {romw(1, 3, 3), romw(1, 2, 3), romw(1, 1, 3), romw(1, 0, 3)});
        chk("R6 fetch rvalid", pf_rvalid, 1);
        @(negedge clk); idle_all();
    endtask

    task automatic t_bank_conflict();
        @(negedge clk); drv_d0(0, 32'h0000_0008, 0, 0); drv_d1(0, 32'h0000_0028);
        #1 chk("R1 R4 same bank stall", {d0_gnt, d1_gnt}, 2'b10);
        step();
        chk("R6 stalled read no rvalid", d1_rvalid, 0);
        chk("R7 winner data", d0_rdata, romw(0, 1, 0));
        @(negedge clk); d0_req = 0;
        #1 chk("R1 stalled granted later", d1_gnt, 1);
        step();
        chk("R7 stalled data", d1_rdata, romw(0, 1, 1));
        @(negedge clk); drv_d0(0, 32'h0000_0008, 0, 0); drv_d1(0, 32'h0000_0010);
        #1 chk("R4 different banks", {d0_gnt, d1_gnt}, 2'b11);
        step();
        chk("R4 both data", {d0_rdata, d1_rdata}, {romw(0, 1, 0), romw(0, 2, 0)});
        @(negedge clk); idle_all(); drv_d0(0, 32'h1000_0000, 0, 0); drv_pr(0, 32'h1000_0004);
        #1 chk("R4 wide access covers pair", {d0_gnt, pr_gnt}, 2'b10);
        @(negedge clk); pr_addr = 32'h1000_0008;
        #1 chk("R4 next bank free", {d0_gnt, pr_gnt}, 2'b11);
        @(negedge clk); idle_all(); drv_d1(0, 32'h1000_0008); drv_pr(0, 32'h1000_000C);
        #1 chk("R1 d1 over pr", {d1_gnt, pr_gnt}, 2'b10);
        @(negedge clk); idle_all();
    endtask

    task automatic t_fetch_conflict();
        @(negedge clk); pf_req = 1; pf_addr = 32'h0000_0000; drv_d1(0, 32'h0000_0018);
        #1 chk("R5 fetch vs data same page", {d1_gnt, pf_gnt}, 2'b10);
        @(negedge clk); idle_all(); pf_req = 1; pf_addr = 32'h0004_0000;
        drv_d0(0, 32'h0000_0000, 0, 0); drv_d1(0, 32'h0000_0008);
        #1 chk("R5 fetch other page", {d0_gnt, d1_gnt, pf_gnt}, 3'b111);
        @(negedge clk); idle_all();
    endtask

    task automatic t_cap();
        @(negedge clk);
        drv_d0(0, 32'h0000_0000, 0, 0); drv_d1(0, 32'h0000_0008);
        drv_pr(0, 32'h0004_0000); pf_req = 1; pf_addr = 32'h1000_0000;
        #1 chk("R2 three grants", {d0_gnt, d1_gnt, pr_gnt, pf_gnt}, 4'b1110);
        step();
        chk("R6 capped fetch no rvalid", pf_rvalid, 0);
        @(negedge clk); d0_req = 0; d1_req = 0; pr_req = 0;
        #1 chk("R2 fetch granted after", pf_gnt, 1);
        step();
        chk("R7 R9 ram line", pf_rdata,
            {32'h0, 32'h0, 32'h0, 32'h0, 32'h1122_3344, 32'hBBBB_BBBB, 32'h0, 32'h0});
        @(negedge clk); idle_all();
    endtask

    task automatic t_unmapped();
        @(negedge clk); drv_d0(0, 32'h2000_0000, 0, 0); drv_d1(1, 32'h2000_0000);
        #1 chk("R3 unmapped no conflict", {d0_gnt, d1_gnt}, 2'b11);
        step();
        chk("R3 unmapped reads zero", d0_rdata, 0);
        @(negedge clk); idle_all(); drv_d0(0, 32'h2000_0000, 0, 0);
        step();
        chk("R3 unmapped write dropped", d0_rdata, 0);
        @(negedge clk); idle_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step();
        step();
        t_reset();
        t_ram_be();
        t_rom_write();
        t_rom_read();
        t_bank_conflict();
        t_fetch_conflict();
        t_cap();
        t_unmapped();
        step();
        finish_run();
    end

endmodule